// File: doc/BRIEF.md
# Edge-Cleared Watchdog Timer

This block watches one activity line driven by a processor. Firmware proves it is alive by toggling the line. A rising transition and a falling transition both count as a kick. If neither arrives for a programmable number of clock cycles, the active-low watchdog output drops. It stays low until a later event clears the counter. The line is sampled through a synchronizer, so it may come from any clock domain.

Two other inputs hold the counter at zero, so the watchdog never times out while either is active. One says the activity line is floating, meaning nobody drives it. The other says the system is held in reset. A separate low-supply flag pulls the output low in the same cycle it is raised, whether or not a timeout has happened. The output comes back high in the same cycle the flag drops. Tie the floating flag high and the block becomes a plain low-line indicator. The float and supply flags come from analog sensing elsewhere and arrive as synchronous one-bit levels.

Top module: `edge_watchdog`

## Requirements
- R1: While `rst_ni` is low, the elapsed count is zero and `wdo_no` is high as long as `supply_low_i` is low.
- R2: The count advances by one per clock while no clear is active. No clear is active when `sys_rst_i` is 0, `kick_float_i` is 0 and no synchronized edge is seen. `wdo_no` falls on the cycle the count reaches TIMEOUT_CYCLES, which is TIMEOUT_CYCLES clocks after the last clear.
- R3: A 0-to-1 change on `kick_i` clears the count. The output recovers after the third rising clock edge following the change, because of two synchronizer flops and one edge flop.
- R4: A 1-to-0 change on `kick_i` clears the count with the same three-clock latency as R3.
- R5: While `kick_float_i` is 1, the count is held at zero, so `wdo_no` never falls from a timeout.
- R6: While `sys_rst_i` is 1, the count is held at zero. Counting resumes on the first clock after it returns to 0.
- R7: After a timeout, `wdo_no` stays low, and the count stays at TIMEOUT_CYCLES, until an edge, a floating flag or a system reset clears it.
- R8: While `supply_low_i` is 1, `wdo_no` is 0 in that same cycle, with no clock edge needed. This holds in every counter state, including while the line is floating.
- R9: When `supply_low_i` returns to 0 and no timeout is pending, `wdo_no` is 1 in that same cycle.
- R10: A level on `kick_i` held for only two clock cycles is still seen as an edge and clears the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset of the block's flops |
| sys_rst_i | input | 1 | System reset is active; holds the count at zero |
| kick_i | input | 1 | Activity line from the processor, asynchronous |
| kick_float_i | input | 1 | Activity line is undriven; holds the count at zero |
| supply_low_i | input | 1 | Supply is below its threshold; forces the output low |
| wdo_no | output | 1 | Watchdog output, active low |

## Verification
The hardest case to reach from the ports is a clear landing close to the expiry boundary. A synchronized edge, a float or a system reset that arrives on the cycle the count reaches its limit, or just before or after it, decides whether the output drops. That is only visible if the stimulus runs right up against the limit. The random phase therefore toggles the activity line at rates spread around the timeout, so that many intervals end a few cycles early or a few cycles late. Directed cases pin the three-clock recovery latency, and a two-cycle pulse given after an expiry.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
    // Sources that hold the elapsed count at zero.
    typedef struct packed {
        logic sys_rst;
        logic floating;
        logic kick_edge;
    } clr_src_t;
endpackage

// File: rtl/wdg_kick_sync.sv
module wdg_kick_sync #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic kick_i,
    output logic edge_o
);
    localparam int unsigned CHAIN_W = SYNC_STAGES + 1;

    typedef struct packed {
        logic [CHAIN_W-1:0] chain;
    } sync_state_t;

    sync_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        state_d.chain = {state_q.chain[CHAIN_W-2:0], kick_i};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    // Top bit is the previous synchronized sample, the one below it the current.
    assign edge_o = state_q.chain[CHAIN_W-1] ^ state_q.chain[CHAIN_W-2];
endmodule

// File: rtl/wdg_counter.sv
module wdg_counter
    import wdg_pkg::*;
#(
    parameter int unsigned TIMEOUT_CYCLES = 1000,
    parameter int unsigned CNT_W = $clog2(TIMEOUT_CYCLES + 1)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  clr_src_t         clr_i,
    output logic [CNT_W-1:0] count_o
);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TIMEOUT_CYCLES);

    typedef struct packed {
        logic [CNT_W-1:0] count;
    } cnt_state_t;

    cnt_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (|clr_i) begin
            state_d.count = '0;
        end else if (state_q.count != LIMIT) begin
            state_d.count = state_q.count + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign count_o = state_q.count;
endmodule

// File: rtl/edge_watchdog.sv
module edge_watchdog
    import wdg_pkg::*;
#(
    parameter int unsigned TIMEOUT_CYCLES = 1000,
    parameter int unsigned SYNC_STAGES    = 2,
    localparam int unsigned CNT_W = $clog2(TIMEOUT_CYCLES + 1)
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic sys_rst_i,
    input  logic kick_i,
    input  logic kick_float_i,
    input  logic supply_low_i,
    output logic wdo_no
);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TIMEOUT_CYCLES);

    logic             kick_edge;
    logic [CNT_W-1:0] wd_count;
    logic             wd_expired;
    clr_src_t         clr_src;

    wdg_kick_sync #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .kick_i (kick_i),
        .edge_o (kick_edge)
    );

    always_comb begin
        clr_src.sys_rst   = sys_rst_i;
        clr_src.floating  = kick_float_i;
        clr_src.kick_edge = kick_edge;
    end

    wdg_counter #(
        .TIMEOUT_CYCLES(TIMEOUT_CYCLES),
        .CNT_W         (CNT_W)
    ) u_cnt (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .clr_i   (clr_src),
        .count_o (wd_count)
    );

    assign wd_expired = (wd_count == LIMIT);
    // The supply flag acts without a register, so the output has no minimum low time.
    assign wdo_no = ~(wd_expired | supply_low_i);
endmodule

// File: rtl/wdg_checker.sv
module wdg_checker #(
    parameter int unsigned TIMEOUT_CYCLES = 1000,
    parameter int unsigned CNT_W = 10
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             sys_rst_i,
    input logic             kick_float_i,
    input logic             supply_low_i,
    input logic             kick_edge,
    input logic [CNT_W-1:0] wd_count,
    input logic             wdo_no
);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TIMEOUT_CYCLES);

    logic any_clr;
    assign any_clr = sys_rst_i | kick_float_i | kick_edge;

    p_count_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!any_clr && wd_count != LIMIT) |=> (wd_count == $past(wd_count) + 1'b1));

    p_edge_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        kick_edge |=> (wd_count == '0));

    p_float_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        kick_float_i |=> (wd_count == '0));

    p_sysrst_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sys_rst_i |=> (wd_count == '0));

    p_sticky_expiry_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wd_count == LIMIT && !any_clr) |=> (wd_count == LIMIT && !wdo_no));

    p_low_supply_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        supply_low_i |-> !wdo_no);

    p_output_high_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!supply_low_i && wd_count != LIMIT) |-> wdo_no);

    p_no_overrun_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wd_count <= LIMIT);
endmodule

bind edge_watchdog wdg_checker #(
    .TIMEOUT_CYCLES(TIMEOUT_CYCLES),
    .CNT_W         (CNT_W)
) u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sys_rst_i    (sys_rst_i),
    .kick_float_i (kick_float_i),
    .supply_low_i (supply_low_i),
    .kick_edge    (kick_edge),
    .wd_count     (wd_count),
    .wdo_no       (wdo_no)
);

// File: tb/edge_watchdog_tb.sv
module edge_watchdog_tb;
    localparam int T = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sys_rst = 1'b1;
    logic kick = 1'b0;
    logic flt = 1'b0;
    logic slow = 1'b0;
    logic wdo_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    edge_watchdog #(.TIMEOUT_CYCLES(T)) u_dut (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .sys_rst_i    (sys_rst),
        .kick_i       (kick),
        .kick_float_i (flt),
        .supply_low_i (slow),
        .wdo_no       (wdo_n)
    );

    // Reference: three-clock edge latency, clear sources, saturating count.
    logic [2:0] m_ch;
    int m_cnt;
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_ch  <= '0;
            m_cnt <= 0;
        end else begin
            m_ch <= {m_ch[1:0], kick};
            if (sys_rst || flt || (m_ch[2] ^ m_ch[1])) m_cnt <= 0;
            else if (m_cnt < T) m_cnt <= m_cnt + 1;
        end
    end

    function automatic logic exp_out(int cnt, logic low);
        return !(cnt == T) && !low;
    endfunction

    task automatic check(string tag, logic got, logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s wdo_no actual=%0b expected=%0b at %0t", tag, got, exp, $time);
        end
    endtask

    // Advance one clock; inputs may change right after, sampling 1 ns later.
    task automatic tick();
        @(negedge clk);
    endtask

    task automatic run_until_expired();
        for (int i = 0; i < T + 5; i++) tick();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        // R1: reset state
        repeat (3) tick();
        #1 check("R1", wdo_n, 1'b1);
        rst_n = 1'b1;
        repeat (5) tick();
        #1 check("R6", wdo_n, 1'b1);

        // R2: exact timeout from release of system reset
        tick(); sys_rst = 1'b0;
        for (int i = 1; i <= T; i++) begin
            tick(); #1;
            if (i == T - 1) check("R2 before limit", wdo_n, 1'b1);
            if (i == T)     check("R2 at limit", wdo_n, 1'b0);
        end
        // R7: stays low
        repeat (10) tick();
        #1 check("R7", wdo_n, 1'b0);

        // R3: rising edge recovers after third clock
        tick(); kick = 1'b1;
        tick(); tick(); #1 check("R3 latency", wdo_n, 1'b0);
        tick(); #1 check("R3 cleared", wdo_n, 1'b1);

        // R4: falling edge
        run_until_expired();
        #1 check("R7 second expiry", wdo_n, 1'b0);
        tick(); kick = 1'b0;
        tick(); tick(); #1 check("R4 latency", wdo_n, 1'b0);
        tick(); #1 check("R4 cleared", wdo_n, 1'b1);

        // R10: two-cycle pulse after expiry
        run_until_expired();
        tick(); kick = 1'b1;
        tick(); tick(); kick = 1'b0;
        #1 check("R10 pulse pending", wdo_n, 1'b0);
        tick(); #1 check("R10 pulse cleared", wdo_n, 1'b1);
        repeat (4) tick();

        // R5: floating holds clear; also clears an expired state
        run_until_expired();
        tick(); flt = 1'b1;
        tick(); #1 check("R5 clears expiry", wdo_n, 1'b1);
        repeat (3 * T) tick();
        #1 check("R5 hold", wdo_n, 1'b1);
        // R8: low-line indicator while floating, same cycle
        tick(); slow = 1'b1; #1 check("R8 floating", wdo_n, 1'b0);
        tick(); slow = 1'b0; #1 check("R9 return", wdo_n, 1'b1);
        tick(); flt = 1'b0;
        for (int i = 1; i <= T; i++) begin
            tick(); #1;
            if (i == T) check("R2 after float", wdo_n, 1'b0);
        end

        // R6: system reset clears and holds
        tick(); sys_rst = 1'b1;
        tick(); #1 check("R6 clears", wdo_n, 1'b1);
        repeat (3 * T) tick();
        #1 check("R6 hold", wdo_n, 1'b1);
        tick(); sys_rst = 1'b0;
        repeat (T / 2) tick();
        // R8 mid-count, R9 back high at once
        tick(); slow = 1'b1; #1 check("R8 mid count", wdo_n, 1'b0);
        tick(); slow = 1'b0; #1 check("R9 mid count", wdo_n, 1'b1);

        // Random phase against the reference model
        for (int ph = 0; ph < 40; ph++) begin
            int rate = T / 2 + int'($urandom_range(0, T));
            for (int c = 0; c < 500; c++) begin
                tick();
                if ($urandom_range(0, rate) == 0) kick = ~kick;
                if ($urandom_range(0, 299) == 0) sys_rst = ~sys_rst;
                else if (sys_rst && $urandom_range(0, 3) == 0) sys_rst = 1'b0;
                if ($urandom_range(0, 199) == 0) flt = ~flt;
                else if (flt && $urandom_range(0, 7) == 0) flt = 1'b0;
                slow = ($urandom_range(0, 49) == 0);
                #1;
                if (slow) check("R8 random", wdo_n, exp_out(m_cnt, slow));
                else if (m_cnt == T) check("R7 random", wdo_n, exp_out(m_cnt, slow));
                else check("R2 random", wdo_n, exp_out(m_cnt, slow));
            end
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule